// File: doc/BRIEF.md
# Beacon Serial Command Interpreter

This block sits behind the byte-level receiver of a slow-CW beacon's serial port (57600 baud, 8N1). It takes one received byte per `rx_valid` pulse and sends the same byte back on the transmit path one cycle later. Single-letter commands change the beacon's settings: keying mode, sending speed, tone shift, carrier frequency and a signed calibration trim. Each change raises a one-cycle save strobe, so that an external store can persist the settings across resets.

For a parameterised number of cycles after reset a frequency-entry window is open, and `entry_ready` is high while it lasts. A decimal digit that arrives inside the window does not select a speed. It starts a fixed-length digit string that becomes the new carrier frequency. One command letter switches the interpreter into message entry. In that mode printable characters are collected into a small buffer until a carriage return ends the message.

Top module: `beacon_cmd_interp`

## Requirements
- R1: Every byte accepted with `rx_valid` appears on `tx_byte` with `tx_valid` high exactly one cycle later, and `tx_valid` is low in every other cycle.
- R2: Outside message and frequency entry, `q`, `d`, `f` and `c` set `mode` to 0, 1, 2 and 3 respectively.
- R3: Outside frequency entry and message entry, the digits `1`, `3` and `6` set `speed` to 10, 3 and 6.
- R4: `a` raises and `z` lowers `shift_hz` by 1. The value stays within 0 and 2^OFS_W-1.
- R5: `s` raises and `x` lowers `freq_hz` by 10. The value stays within 0 and FREQ_MAX (99,999,999 by default).
- R6: `h` raises and `n` lowers the two's-complement `cal` by 1. The value stays within the signed range of CAL_W bits.
- R7: `entry_ready` is high for WINDOW_CYCLES cycles after reset. It goes low when the window expires or when a digit starts frequency entry, and it stays low until the next reset.
- R8: A digit received while `entry_ready` is high starts frequency entry, shown by `entry_busy`. That digit and the next DIGITS-1 digits, most significant first, become `freq_hz` on the last digit.
- R9: A non-digit byte received during frequency entry ends the entry. The frequency stays unchanged and the byte is not treated as a command.
- R10: `save_req` pulses for one cycle, one cycle after each mode, speed, shift, frequency or calibration command, after a completed frequency entry and after the carriage return that ends a message. It stays low for every other byte.
- R11: `m` sets `msg_active` and clears `msg_len`. While `msg_active` is high, bytes 0x20 to 0x7E are stored at address `msg_len` (up to MSG_DEPTH) and are not decoded as commands. Other bytes are ignored. Carriage return (0x0D) clears `msg_active`. Stored characters are read on `msg_rd_data` at `msg_rd_addr`.
- R12: `r` pulses `reset_req` for one cycle, one cycle after the byte, and changes no setting.
- R13: Any other byte is echoed but changes no setting and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Echo byte is valid |
| tx_byte | output | 8 | Echo byte |
| mode | output | 2 | Keying mode: 0 slow CW, 1 dual-frequency CW, 2 shift-keyed CW, 3 plain CW |
| speed | output | 7 | Speed setting |
| freq_hz | output | FREQ_W | Carrier frequency in Hz |
| shift_hz | output | OFS_W | Shift offset in Hz |
| cal | output | CAL_W | Signed calibration trim |
| save_req | output | 1 | One-cycle request to persist the settings |
| reset_req | output | 1 | One-cycle device reset request |
| entry_ready | output | 1 | Frequency-entry window open |
| entry_busy | output | 1 | Frequency digits being collected |
| msg_active | output | 1 | Message entry in progress |
| msg_len | output | clog2(MSG_DEPTH+1) | Number of stored message characters |
| msg_rd_addr | input | clog2(MSG_DEPTH) | Message read address |
| msg_rd_data | output | 8 | Message character at the read address |

## Verification
The bench builds the block with a 40-cycle entry window, an 8-character message buffer and a 4-bit calibration field, and leaves shift and frequency at full width. With the short window, expiry falls inside a short run, and several resets can exercise both the aborted and the completed digit string. The small buffer lets the overflow case, where characters are dropped, be reached. With 4-bit calibration, both signed limits can be reached by sweeping one key. With the initial frequency set to 25 Hz, and with a full digit string that writes 99,999,995, both frequency limits are near enough to reach. The 8-bit shift is swept across its whole range.

// File: rtl/beacon_pkg.sv
package beacon_pkg;

   localparam int SPD_W = 7;

   typedef enum logic [1:0] {
      MODE_QRSS  = 2'd0,
      MODE_DFCW  = 2'd1,
      MODE_FSKCW = 2'd2,
      MODE_CW    = 2'd3
   } bcn_mode_e;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_MODE,
      OP_SPEED,
      OP_SHF_UP,
      OP_SHF_DN,
      OP_FRQ_UP,
      OP_FRQ_DN,
      OP_CAL_UP,
      OP_CAL_DN,
      OP_MSG,
      OP_RST
   } bcn_op_e;

   typedef struct packed {
      bcn_op_e            op;
      bcn_mode_e          mode;
      logic [SPD_W-1:0]   speed;
      logic               is_digit;
      logic [3:0]         digit;
      logic               printable;
      logic               is_cr;
   } bcn_decode_t;

   localparam logic [7:0] CH_CR = 8'h0D;

endpackage

// File: rtl/bcn_decoder.sv
module bcn_decoder
   import beacon_pkg::*;
(
   input  logic [7:0]  byte_in,
   output bcn_decode_t dec
);

   always_comb begin
      dec           = '0;
      dec.op        = OP_NONE;
      dec.mode      = MODE_QRSS;
      dec.is_digit  = (byte_in >= 8'h30) && (byte_in <= 8'h39);
      dec.digit     = byte_in[3:0];
      dec.printable = (byte_in >= 8'h20) && (byte_in <= 8'h7E);
      dec.is_cr     = (byte_in == CH_CR);
      case (byte_in)
         8'h71: begin dec.op = OP_MODE;  dec.mode = MODE_QRSS;  end // q
         8'h64: begin dec.op = OP_MODE;  dec.mode = MODE_DFCW;  end // d
         8'h66: begin dec.op = OP_MODE;  dec.mode = MODE_FSKCW; end // f
         8'h63: begin dec.op = OP_MODE;  dec.mode = MODE_CW;    end // c
         8'h31: begin dec.op = OP_SPEED; dec.speed = SPD_W'(10); end
         8'h33: begin dec.op = OP_SPEED; dec.speed = SPD_W'(3);  end
         8'h36: begin dec.op = OP_SPEED; dec.speed = SPD_W'(6);  end
         8'h61: dec.op = OP_SHF_UP;  // a
         8'h7A: dec.op = OP_SHF_DN;  // z
         8'h73: dec.op = OP_FRQ_UP;  // s
         8'h78: dec.op = OP_FRQ_DN;  // x
         8'h68: dec.op = OP_CAL_UP;  // h
         8'h6E: dec.op = OP_CAL_DN;  // n
         8'h6D: dec.op = OP_MSG;     // m
         8'h72: dec.op = OP_RST;     // r
         default: dec.op = OP_NONE;
      endcase
   end

endmodule

// File: rtl/bcn_freq_entry.sv
module bcn_freq_entry #(
   parameter int WINDOW_CYCLES = 1000000,
   parameter int DIGITS        = 8,
   localparam int ACC_W        = 4 * DIGITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_valid,
   input  logic             is_digit,
   input  logic [3:0]       digit,
   output logic             window_open,
   output logic             busy,
   output logic             claim,
   output logic             done,
   output logic [ACC_W-1:0] value
);

   localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
   localparam int DIG_W = $clog2(DIGITS + 1);

   logic              open_q;
   logic              busy_q;
   logic [CNT_W-1:0]  win_cnt;
   logic [DIG_W-1:0]  dig_cnt;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_next;
   logic              start;
   logic              last;

   assign acc_next    = acc_q * ACC_W'(10) + ACC_W'(digit);
   assign start       = byte_valid && open_q && is_digit && !busy_q;
   assign last        = busy_q && is_digit && (dig_cnt == DIG_W'(DIGITS - 1));
   assign claim       = byte_valid && (busy_q || (open_q && is_digit));
   assign done        = byte_valid && last;
   assign value       = acc_next;
   assign window_open = open_q;
   assign busy        = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b1;
         busy_q  <= 1'b0;
         win_cnt <= '0;
         dig_cnt <= '0;
         acc_q   <= '0;
      end else begin
         if (open_q) begin
            if (win_cnt == CNT_W'(WINDOW_CYCLES - 1)) open_q <= 1'b0;
            else                                       win_cnt <= win_cnt + 1'b1;
         end
         if (start) begin
            open_q  <= 1'b0;
            busy_q  <= 1'b1;
            acc_q   <= ACC_W'(digit);
            dig_cnt <= DIG_W'(1);
         end else if (busy_q && byte_valid) begin
            if (!is_digit || last) begin
               busy_q <= 1'b0;
            end else begin
               acc_q   <= acc_next;
               dig_cnt <= dig_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bcn_msg_store.sv
module bcn_msg_store #(
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             byte_valid,
   input  logic [7:0]       byte_in,
   input  logic             printable,
   input  logic             is_cr,
   input  logic [AW-1:0]    rd_addr,
   output logic [7:0]       rd_data,
   output logic [LEN_W-1:0] len,
   output logic             active,
   output logic             done
);

   logic [7:0]       mem [DEPTH];
   logic             active_q;
   logic [LEN_W-1:0] len_q;
   logic             room;
   logic             wr;

   assign room   = (len_q < LEN_W'(DEPTH));
   assign wr     = active_q && byte_valid && !is_cr && printable && room;
   assign done   = active_q && byte_valid && is_cr;
   assign active = active_q;
   assign len    = len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         len_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         len_q    <= '0;
      end else if (done) begin
         active_q <= 1'b0;
      end else if (wr) begin
         len_q <= len_q + 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (wr && (len_q == LEN_W'(i))) mem[i] <= byte_in;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      if ({1'b0, rd_addr} < (AW + 1)'(DEPTH)) rd_data = mem[rd_addr];
   end

endmodule

// File: rtl/beacon_cmd_interp.sv
module beacon_cmd_interp
   import beacon_pkg::*;
#(
   parameter int FREQ_W        = 27,
   parameter int FREQ_MAX      = 99999999,
   parameter int FREQ_INIT     = 10140080,
   parameter int FREQ_STEP     = 10,
   parameter int OFS_W         = 8,
   parameter int OFS_INIT      = 10,
   parameter int CAL_W         = 16,
   parameter int CAL_INIT      = 0,
   parameter int SPEED_INIT    = 3,
   parameter int DIGITS        = 8,
   parameter int WINDOW_CYCLES = 1000000,
   parameter int MSG_DEPTH     = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rx_valid,
   input  logic [7:0]                     rx_byte,
   output logic                           tx_valid,
   output logic [7:0]                     tx_byte,
   output logic [1:0]                     mode,
   output logic [SPD_W-1:0]               speed,
   output logic [FREQ_W-1:0]              freq_hz,
   output logic [OFS_W-1:0]               shift_hz,
   output logic [CAL_W-1:0]               cal,
   output logic                           save_req,
   output logic                           reset_req,
   output logic                           entry_ready,
   output logic                           entry_busy,
   output logic                           msg_active,
   output logic [$clog2(MSG_DEPTH+1)-1:0] msg_len,
   input  logic [$clog2(MSG_DEPTH)-1:0]   msg_rd_addr,
   output logic [7:0]                     msg_rd_data
);

   localparam int ACC_W = 4 * DIGITS;
   localparam logic [FREQ_W-1:0] F_MAX  = FREQ_W'(FREQ_MAX);
   localparam logic [FREQ_W-1:0] F_STEP = FREQ_W'(FREQ_STEP);
   localparam logic [OFS_W-1:0]  S_MAX  = {OFS_W{1'b1}};
   localparam logic [CAL_W-1:0]  C_HI   = {1'b0, {(CAL_W-1){1'b1}}};
   localparam logic [CAL_W-1:0]  C_LO   = {1'b1, {(CAL_W-1){1'b0}}};
   localparam logic [CAL_W-1:0]  C_ONE  = CAL_W'(1);

   if (FREQ_MAX >= 2 ** FREQ_W)  begin : g_chk_fw  $error("FREQ_MAX does not fit FREQ_W"); end
   if (FREQ_INIT > FREQ_MAX)     begin : g_chk_fi  $error("FREQ_INIT above FREQ_MAX"); end
   if (ACC_W < FREQ_W)           begin : g_chk_acc $error("DIGITS too few for FREQ_W"); end
   if (FREQ_STEP > FREQ_MAX)     begin : g_chk_fs  $error("FREQ_STEP above FREQ_MAX"); end
   if (CAL_W < 2)                begin : g_chk_cw  $error("CAL_W below 2"); end
   if (MSG_DEPTH < 2)            begin : g_chk_md  $error("MSG_DEPTH below 2"); end
   if (WINDOW_CYCLES < 1)        begin : g_chk_wc  $error("WINDOW_CYCLES below 1"); end

   bcn_decode_t       dec;
   logic              ent_claim;
   logic              ent_done;
   logic [ACC_W-1:0]  ent_value;
   logic              msg_done;
   logic              msg_start;
   logic              cmd_valid;
   logic              msg_act_w;

   bcn_mode_e          mode_q;
   logic [SPD_W-1:0]   speed_q;
   logic [FREQ_W-1:0]  freq_q;
   logic [OFS_W-1:0]   shift_q;
   logic [CAL_W-1:0]   cal_q;
   logic               tx_v_q;
   logic [7:0]         tx_b_q;
   logic               save_q;
   logic               rst_q;

   bcn_decoder u_dec (
      .byte_in (rx_byte),
      .dec     (dec)
   );

   bcn_freq_entry #(
      .WINDOW_CYCLES (WINDOW_CYCLES),
      .DIGITS        (DIGITS)
   ) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_valid  (rx_valid && !msg_act_w),
      .is_digit    (dec.is_digit),
      .digit       (dec.digit),
      .window_open (entry_ready),
      .busy        (entry_busy),
      .claim       (ent_claim),
      .done        (ent_done),
      .value       (ent_value)
   );

   assign cmd_valid = rx_valid && !msg_act_w && !ent_claim;
   assign msg_start = cmd_valid && (dec.op == OP_MSG);

   bcn_msg_store #(
      .DEPTH (MSG_DEPTH)
   ) u_msg (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (msg_start),
      .byte_valid (rx_valid),
      .byte_in    (rx_byte),
      .printable  (dec.printable),
      .is_cr      (dec.is_cr),
      .rd_addr    (msg_rd_addr),
      .rd_data    (msg_rd_data),
      .len        (msg_len),
      .active     (msg_act_w),
      .done       (msg_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_QRSS;
         speed_q <= SPD_W'(SPEED_INIT);
         freq_q  <= FREQ_W'(FREQ_INIT);
         shift_q <= OFS_W'(OFS_INIT);
         cal_q   <= CAL_W'(CAL_INIT);
         tx_v_q  <= 1'b0;
         tx_b_q  <= 8'h00;
         save_q  <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         tx_v_q <= rx_valid;
         if (rx_valid) tx_b_q <= rx_byte;
         save_q <= 1'b0;
         rst_q  <= 1'b0;
         if (ent_done) begin
            freq_q <= (ent_value > ACC_W'(FREQ_MAX)) ? F_MAX : ent_value[FREQ_W-1:0];
            save_q <= 1'b1;
         end else if (msg_done) begin
            save_q <= 1'b1;
         end else if (cmd_valid) begin
            case (dec.op)
               OP_MODE:   begin mode_q <= dec.mode; save_q <= 1'b1; end
               OP_SPEED:  begin speed_q <= dec.speed; save_q <= 1'b1; end
               OP_SHF_UP: begin
                  if (shift_q != S_MAX) shift_q <= shift_q + 1'b1;
                  save_q <= 1'b1;
               end
               OP_SHF_DN: begin
                  if (shift_q != '0) shift_q <= shift_q - 1'b1;
                  save_q <= 1'b1;
               end
               OP_FRQ_UP: begin
                  freq_q <= (freq_q > F_MAX - F_STEP) ? F_MAX : freq_q + F_STEP;
                  save_q <= 1'b1;
               end
               OP_FRQ_DN: begin
                  freq_q <= (freq_q < F_STEP) ? '0 : freq_q - F_STEP;
                  save_q <= 1'b1;
               end
               OP_CAL_UP: begin
                  if (cal_q != C_HI) cal_q <= cal_q + C_ONE;
                  save_q <= 1'b1;
               end
               OP_CAL_DN: begin
                  if (cal_q != C_LO) cal_q <= cal_q - C_ONE;
                  save_q <= 1'b1;
               end
               OP_RST:    rst_q <= 1'b1;
               default:   ;
            endcase
         end
      end
   end

   assign mode       = mode_q;
   assign speed      = speed_q;
   assign freq_hz    = freq_q;
   assign shift_hz   = shift_q;
   assign cal        = cal_q;
   assign tx_valid   = tx_v_q;
   assign tx_byte    = tx_b_q;
   assign save_req   = save_q;
   assign reset_req  = rst_q;
   assign msg_active = msg_act_w;

endmodule

// File: rtl/bcn_checker.sv
module bcn_checker #(
   parameter int FREQ_W    = 27,
   parameter int FREQ_MAX  = 99999999,
   parameter int MSG_DEPTH = 64
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           rx_valid,
   input logic [7:0]                     rx_byte,
   input logic                           tx_valid,
   input logic [7:0]                     tx_byte,
   input logic [FREQ_W-1:0]              freq_hz,
   input logic                           save_req,
   input logic                           reset_req,
   input logic                           entry_ready,
   input logic [$clog2(MSG_DEPTH+1)-1:0] msg_len
);

   assert_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (tx_valid && tx_byte == $past(rx_byte)));

   assert_quiet_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !tx_valid);

   assert_freq_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      freq_hz <= FREQ_W'(FREQ_MAX));

   assert_freq_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(freq_hz));

   assert_freq_saved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq_hz) |-> save_req);

   assert_window_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_ready |=> !entry_ready);

   assert_rst_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_byte != 8'h72 |=> !reset_req);

   assert_msg_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_len <= ($clog2(MSG_DEPTH+1))'(MSG_DEPTH));

endmodule

bind beacon_cmd_interp bcn_checker #(
   .FREQ_W    (FREQ_W),
   .FREQ_MAX  (FREQ_MAX),
   .MSG_DEPTH (MSG_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_valid    (rx_valid),
   .rx_byte     (rx_byte),
   .tx_valid    (tx_valid),
   .tx_byte     (tx_byte),
   .freq_hz     (freq_hz),
   .save_req    (save_req),
   .reset_req   (reset_req),
   .entry_ready (entry_ready),
   .msg_len     (msg_len)
);

// File: tb/sim_beacon_cmd_interp.sv
module sim_beacon_cmd_interp;

   localparam int FW    = 27;
   localparam int OW    = 8;
   localparam int CW    = 4;
   localparam int WIN   = 40;
   localparam int DEP   = 8;
   localparam int FINIT = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_byte = 8'h00;
   logic          tx_valid;
   logic [7:0]    tx_byte;
   logic [1:0]    mode;
   logic [6:0]    speed;
   logic [FW-1:0] freq_hz;
   logic [OW-1:0] shift_hz;
   logic [CW-1:0] cal;
   logic          save_req, reset_req, entry_ready, entry_busy, msg_active;
   logic [3:0]    msg_len;
   logic [2:0]    msg_rd_addr = 3'd0;
   logic [7:0]    msg_rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   int m_mode, m_speed, m_freq, m_shift, m_cal;

   always #4 clk = ~clk;

   beacon_cmd_interp #(
      .FREQ_W (FW), .FREQ_INIT (FINIT), .OFS_W (OW), .OFS_INIT (2),
      .CAL_W (CW), .CAL_INIT (0), .SPEED_INIT (3),
      .WINDOW_CYCLES (WIN), .MSG_DEPTH (DEP)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
      .tx_valid (tx_valid), .tx_byte (tx_byte), .mode (mode), .speed (speed),
      .freq_hz (freq_hz), .shift_hz (shift_hz), .cal (cal),
      .save_req (save_req), .reset_req (reset_req),
      .entry_ready (entry_ready), .entry_busy (entry_busy),
      .msg_active (msg_active), .msg_len (msg_len),
      .msg_rd_addr (msg_rd_addr), .msg_rd_data (msg_rd_data)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic chk_settings(input string tag);
      chk({tag, " mode R2"},  int'(mode), m_mode);
      chk({tag, " speed R3"}, int'(speed), m_speed);
      chk({tag, " shift R4"}, int'(shift_hz), m_shift);
      chk({tag, " freq R5"},  int'(freq_hz), m_freq);
      chk({tag, " cal R6"},   int'($signed(cal)), m_cal);
   endtask

   task automatic send(input logic [7:0] b, input bit e_save, input bit e_rst, input string tag);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      chk({tag, " echo valid R1"}, int'(tx_valid), 1);
      chk({tag, " echo byte R1"},  int'(tx_byte), int'(b));
      chk({tag, " save R10"},      int'(save_req), int'(e_save));
      chk({tag, " reset strobe R12"}, int'(reset_req), int'(e_rst));
      chk_settings(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      m_mode  = 0; m_speed = 3; m_freq = FINIT; m_shift = 2; m_cal = 0;
      @(negedge clk);
      chk("reset tx_valid R1", int'(tx_valid), 0);
      chk("reset save R10", int'(save_req), 0);
      chk("reset ready R7", int'(entry_ready), 1);
      chk("reset busy R8", int'(entry_busy), 0);
      chk("reset msg R11", int'(msg_active), 0);
      chk_settings("reset");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] stored [8];
      string digs;
      do_reset();

      // R9: a digit starts entry, a letter aborts it without acting as a command
      send("9", 0, 0, "R9 first digit");
      chk("R8 busy after digit", int'(entry_busy), 1);
      chk("R7 ready after digit", int'(entry_ready), 0);
      send("d", 0, 0, "R9 abort letter");
      chk("R9 busy after abort", int'(entry_busy), 0);

      // R2 mode letters
      m_mode = 1; send("d", 1, 0, "R2 d");
      m_mode = 2; send("f", 1, 0, "R2 f");
      m_mode = 3; send("c", 1, 0, "R2 c");
      m_mode = 0; send("q", 1, 0, "R2 q");

      // R3 speeds
      m_speed = 10; send("1", 1, 0, "R3 one");
      m_speed = 3;  send("3", 1, 0, "R3 three");
      m_speed = 6;  send("6", 1, 0, "R3 six");

      // R4 shift sweep with both limits
      for (int i = 0; i < 3; i++) begin
         m_shift = (m_shift == 0) ? 0 : m_shift - 1;
         send("z", 1, 0, "R4 down");
      end
      for (int i = 0; i < 260; i++) begin
         m_shift = (m_shift == 255) ? 255 : m_shift + 1;
         send("a", 1, 0, "R4 up");
      end

      // R5 lower limit
      for (int i = 0; i < 4; i++) begin
         m_freq = (m_freq < 10) ? 0 : m_freq - 10;
         send("x", 1, 0, "R5 down");
      end
      m_freq = 10; send("s", 1, 0, "R5 up");

      // R6 signed limits
      for (int i = 0; i < 10; i++) begin
         m_cal = (m_cal == 7) ? 7 : m_cal + 1;
         send("h", 1, 0, "R6 up");
      end
      for (int i = 0; i < 20; i++) begin
         m_cal = (m_cal == -8) ? -8 : m_cal - 1;
         send("n", 1, 0, "R6 down");
      end

      // R13 unknown bytes, R12 reset request
      send("k", 0, 0, "R13 k");
      send(8'h23, 0, 0, "R13 hash");
      send(8'h00, 0, 0, "R13 nul");
      send("r", 0, 1, "R12 r");

      // R11 message entry
      send("m", 0, 0, "R11 start");
      chk("R11 active", int'(msg_active), 1);
      chk("R11 len cleared", int'(msg_len), 0);
      stored[0] = "H"; stored[1] = "i"; stored[2] = "q";
      send("H", 0, 0, "R11 char");
      send("i", 0, 0, "R11 char");
      send(8'h01, 0, 0, "R11 control ignored");
      send("q", 0, 0, "R11 letter stored");
      for (int i = 0; i < 6; i++) begin
         if (i < 5) stored[3 + i] = 8'h41 + 8'(i);
         send(8'h41 + 8'(i), 0, 0, "R11 fill");
      end
      chk("R11 len full", int'(msg_len), 8);
      send(8'h0D, 1, 0, "R11 carriage return");
      chk("R11 inactive", int'(msg_active), 0);
      for (int i = 0; i < 8; i++) begin
         msg_rd_addr = 3'(i);
         #1;
         chk("R11 readback", int'(msg_rd_data), int'(stored[i]));
      end

      // R8 full digit string, then R5 upper limit
      do_reset();
      digs = "99999995";
      for (int i = 0; i < 8; i++) begin
         if (i == 7) m_freq = 99999995;
         send(digs[i], i == 7, 0, "R8 digit");
         chk("R8 busy", int'(entry_busy), (i == 7) ? 0 : 1);
      end
      m_freq = 99999999; send("s", 1, 0, "R5 top");
      send("s", 1, 0, "R5 top held");

      // R7 window expiry, then R3 digits are speeds
      do_reset();
      repeat (WIN - 10) @(negedge clk);
      chk("R7 ready inside window", int'(entry_ready), 1);
      repeat (20) @(negedge clk);
      chk("R7 ready after window", int'(entry_ready), 0);
      m_speed = 6; send("6", 1, 0, "R3 after window");
      chk("R8 no entry after window", int'(entry_busy), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule